// File: doc/BRIEF.md
# Screen Byte Pixel Serializer

This block turns one fetched screen byte into a run of on-screen pixels. When a fetch has completed and the memory sequencer is in its first stage, the block takes the byte, splits it into palette indices according to the current colour depth (1, 2 or 4 bits per pixel), and then plays those indices out one per clock. Each index is held on the output for a number of clocks set by the display mode's horizontal scale, so low-resolution modes stretch each pixel across several output positions.

The block is a two-state machine. In `ST_IDLE` the output is black and the block waits for a load. The transition `IDLE->SHIFT` happens on a clock where the stage-0 strobe and the pixels-ready flag are both high; the byte, depth code and scale are captured, and a one-cycle acknowledge tells the fetch logic to clear its ready flag so the same fetch is never shown twice. In `ST_SHIFT` the block walks through the slots, and the transition `SHIFT->IDLE` happens when the last slot has been held for its full run. A blanking qualifier (spacing lines between character rows) forces black and freezes progress while it is high.

The multi-bit depths interleave their bits across the byte rather than packing them side by side: a 2-bit pixel takes one bit from the upper nibble and one from the lower, and a 4-bit pixel takes every other bit. The three-bit colour is the low three bits of the index, so indices 8 to 15 repeat colours 0 to 7.

Top module: `pixel_serializer`

## Requirements
- R1: With depth code 0 (1 bit per pixel) the byte yields eight slots; slot k is bit (7-k), so bit 7 is shown first and bit 0 last.
- R2: With depth code 1 (2 bits per pixel) the byte yields four slots; slot k (k = 0..3) is the index {bit(7-k), bit(3-k)}, the first of the two being the index MSB.
- R3: With depth code 2 (4 bits per pixel) the byte yields two slots: slot 0 is {b7,b5,b3,b1} and slot 1 is {b6,b4,b2,b0}, MSB first; depth code 3 behaves exactly as code 2.
- R4: The colour output rgb carries red in rgb[0] = index bit 0, green in rgb[1] = index bit 1 and blue in rgb[2] = index bit 2; index bit 3 has no effect on the colour.
- R5: A load occurs on a clock where the block is idle, stage0 and pix_ready are both high; load_ack is high in exactly that cycle, and the byte, depth code and scale are captured then; the first slot is on rgb from the following cycle.
- R6: Each slot stays on rgb for hscale consecutive unblanked cycles before the next slot is shown; an hscale of 0 behaves as 1.
- R7: While blank is high rgb is black (0) and the slot position and run count do not advance; showing resumes with the same slot and the remaining run when blank falls.
- R8: After the last slot's run the block returns to idle with rgb black; load requests while shifting are not acknowledged and have no effect on the output, and a request in the first idle cycle is acknowledged.
- R9: Out of reset the block is idle, rgb is 0 and load_ack is 0 while no load is requested.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scr_byte | input | 8 | Fetched screen byte |
| pix_ready | input | 1 | A fetched byte is waiting to be shown |
| stage0 | input | 1 | First stage of the memory sequence |
| bpp_sel | input | 2 | Depth code: 0 = 1 bpp, 1 = 2 bpp, 2 or 3 = 4 bpp |
| hscale | input | 4 | Clocks per slot (0 treated as 1) |
| blank | input | 1 | Spacing-line qualifier: force black and stall |
| rgb | output | 3 | Colour: bit 0 red, bit 1 green, bit 2 blue |
| load_ack | output | 1 | Byte taken this cycle; clears the ready flag upstream |

## Verification
Two functions can meet in one cycle: a new load request arriving on the cycle that shows the final slot of the previous byte, and the blanking qualifier rising on the very cycle a byte is loaded or in the middle of a slot's run. The bench raises stage0 and pix_ready during the final slot and judges that no acknowledge appears and the last colour is still shown, then holds the request one more cycle and expects the acknowledge and the new byte's first slot a cycle later. Blanking is raised mid-run and judged by black output for its whole length followed by the interrupted slot finishing exactly its remaining clocks.

// File: rtl/pixel_serializer_pkg.sv
package pixel_serializer_pkg;

    localparam int BYTE_W  = 8;
    localparam int IDX_W   = 4;
    localparam int SLOTS   = 8;
    localparam int COLOR_W = 3;

    typedef enum logic [1:0] {
        DEPTH_1 = 2'd0,
        DEPTH_2 = 2'd1,
        DEPTH_4 = 2'd2,
        DEPTH_4_ALT = 2'd3
    } depth_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } ser_state_t;

    typedef logic [SLOTS-1:0][IDX_W-1:0] slot_vec_t;

endpackage

// File: rtl/pixel_unpack.sv
module pixel_unpack
    import pixel_serializer_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_q,
    input  depth_t            depth,
    output slot_vec_t         slots
);

    slot_vec_t one_bit;
    slot_vec_t two_bit;
    slot_vec_t four_bit;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // single-bit slots, MSB shown first
        assign one_bit[s] = {{(IDX_W-1){1'b0}}, byte_q[7-s]};

        // two-bit slots draw one bit from each nibble
        if (s < 4) begin : g_two
            assign two_bit[s] = {2'b00, byte_q[7-s], byte_q[3-s]};
        end else begin : g_two_pad
            assign two_bit[s] = '0;
        end

        // four-bit slots take alternate bits
        if (s < 2) begin : g_four
            assign four_bit[s] = {byte_q[7-s], byte_q[5-s], byte_q[3-s], byte_q[1-s]};
        end else begin : g_four_pad
            assign four_bit[s] = '0;
        end
    end

    always_comb begin
        unique case (depth)
            DEPTH_1:     slots = one_bit;
            DEPTH_2:     slots = two_bit;
            DEPTH_4,
            DEPTH_4_ALT: slots = four_bit;
            default:     slots = four_bit;
        endcase
    end

endmodule

// File: rtl/run_timer.sv
module run_timer #(
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               advance,
    input  logic [SCALE_W-1:0] scale,
    output logic               run_done
);

    logic [SCALE_W-1:0] run_cnt;
    logic [SCALE_W-1:0] scale_eff;

    assign scale_eff = (scale == '0) ? SCALE_W'(1) : scale;
    assign run_done  = (run_cnt >= scale_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= SCALE_W'(1);
        end else if (restart) begin
            run_cnt <= SCALE_W'(1);
        end else if (advance) begin
            run_cnt <= run_done ? SCALE_W'(1) : run_cnt + SCALE_W'(1);
        end
    end

    // the run count never passes the scale it was started with
    p_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt >= SCALE_W'(1) && run_cnt <= scale_eff);

    // a stalled timer keeps its count
    p_run_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !restart) |=> $stable(run_cnt));

endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
    import pixel_serializer_pkg::*;
#(
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         scr_byte,
    input  logic               pix_ready,
    input  logic               stage0,
    input  logic [1:0]         bpp_sel,
    input  logic [SCALE_W-1:0] hscale,
    input  logic               blank,
    output logic [2:0]         rgb,
    output logic               load_ack
);

    localparam int POS_W = $clog2(SLOTS);

    ser_state_t         state, state_nx;
    logic [BYTE_W-1:0]  byte_q;
    depth_t             depth_q;
    logic [SCALE_W-1:0] scale_q;
    logic [POS_W-1:0]   pos_q;
    logic [POS_W-1:0]   last_pos;
    slot_vec_t          slots;
    logic               do_load;
    logic               step;
    logic               run_done;
    logic               slot_end;

    // ---- slot decode ----
    pixel_unpack u_unpack (
        .byte_q (byte_q),
        .depth  (depth_q),
        .slots  (slots)
    );

    // ---- per-slot repetition ----
    run_timer #(.SCALE_W(SCALE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (do_load),
        .advance  (step),
        .scale    (scale_q),
        .run_done (run_done)
    );

    always_comb begin
        unique case (depth_q)
            DEPTH_1:     last_pos = POS_W'(SLOTS - 1);
            DEPTH_2:     last_pos = POS_W'(SLOTS / 2 - 1);
            DEPTH_4,
            DEPTH_4_ALT: last_pos = POS_W'(SLOTS / 4 - 1);
            default:     last_pos = POS_W'(SLOTS / 4 - 1);
        endcase
    end

    // ---- next-state logic ----
    always_comb begin
        do_load  = 1'b0;
        step     = 1'b0;
        slot_end = 1'b0;
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (stage0 && pix_ready) begin
                    do_load  = 1'b1;
                    state_nx = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                step     = !blank;
                slot_end = step && run_done;
                if (slot_end && pos_q == last_pos) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            byte_q  <= '0;
            depth_q <= DEPTH_1;
            scale_q <= SCALE_W'(1);
            pos_q   <= '0;
        end else begin
            state <= state_nx;
            if (do_load) begin
                byte_q  <= scr_byte;
                depth_q <= depth_t'(bpp_sel);
                scale_q <= hscale;
                pos_q   <= '0;
            end else if (slot_end && pos_q != last_pos) begin
                pos_q <= pos_q + POS_W'(1);
            end
        end
    end

    // ---- outputs ----
    always_comb begin
        load_ack = 1'b0;
        rgb      = '0;
        unique case (state)
            ST_IDLE: begin
                load_ack = do_load;
            end
            ST_SHIFT: begin
                if (!blank) rgb = slots[pos_q][COLOR_W-1:0];
            end
            default: rgb = '0;
        endcase
    end

    // ---- assertions ----
    p_load_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_ack |=> (state == ST_SHIFT && pos_q == '0));

    p_busy_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> !load_ack);

    p_blank_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (rgb == '0));

    p_blank_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && blank) |=> (state == ST_SHIFT && $stable(pos_q)));

    p_pos_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= last_pos);

    p_exit_at_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_SHIFT && state == ST_IDLE) |-> ($past(pos_q) == $past(last_pos)));

endmodule

// File: tb/pixel_serializer_tb.sv
module pixel_serializer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] scr_byte = '0;
    logic       pix_ready = 1'b0;
    logic       stage0 = 1'b0;
    logic [1:0] bpp_sel = '0;
    logic [3:0] hscale = 4'd1;
    logic       blank = 1'b0;
    logic [2:0] rgb;
    logic       load_ack;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pixel_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .scr_byte(scr_byte), .pix_ready(pix_ready),
        .stage0(stage0), .bpp_sel(bpp_sel), .hscale(hscale), .blank(blank),
        .rgb(rgb), .load_ack(load_ack)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int slot_count(input logic [1:0] code);
        return (code == 2'd0) ? 8 : (code == 2'd1) ? 4 : 2;
    endfunction

    // expected colour of slot k, from the bit layouts in R1..R4
    function automatic int exp_color(input logic [7:0] b, input logic [1:0] code, input int k);
        logic [3:0] ix;
        if (code == 2'd0)      ix = {3'b000, b[7-k]};
        else if (code == 2'd1) ix = {2'b00, b[7-k], b[3-k]};
        else                   ix = {b[7-k], b[5-k], b[3-k], b[1-k]};
        return int'(ix[2:0]);
    endfunction

    // request a load at a negedge and check the acknowledge (R5)
    task automatic do_load(input logic [7:0] b, input logic [1:0] code, input logic [3:0] sc);
        @(negedge clk);
        scr_byte = b; bpp_sel = code; hscale = sc;
        stage0 = 1'b1; pix_ready = 1'b1;
        #1 chk("R5 load_ack on request", int'(load_ack), 1);
        @(negedge clk);
        stage0 = 1'b0; pix_ready = 1'b0;
        scr_byte = ~b; hscale = 4'd7;   // captured values must be used
    endtask

    // play one full byte, checking every output position, then idle (R6, R8)
    task automatic play(input logic [7:0] b, input logic [1:0] code, input logic [3:0] sc, input string tag);
        int reps;
        reps = (sc == 0) ? 1 : int'(sc);
        do_load(b, code, sc);
        for (int k = 0; k < slot_count(code); k++) begin
            for (int r = 0; r < reps; r++) begin
                #1 chk(tag, int'(rgb), exp_color(b, code, k));
                @(negedge clk);
            end
        end
        #1 chk("R8 black after last slot", int'(rgb), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk("R9 rgb in reset", int'(rgb), 0);
        chk("R9 load_ack in reset", int'(load_ack), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk("R9 rgb idle after reset", int'(rgb), 0);
        chk("R9 no ack without request", int'(load_ack), 0);
    endtask

    task automatic t_one_bpp;
        play(8'hB4, 2'd0, 4'd1, "R1 1bpp scale1");
        play(8'h5A, 2'd0, 4'd2, "R1 1bpp scale2");
    endtask

    task automatic t_two_bpp;
        play(8'hC6, 2'd1, 4'd2, "R2 2bpp scale2");
        play(8'h39, 2'd1, 4'd1, "R2 2bpp scale1");
    endtask

    task automatic t_four_bpp;
        play(8'hE1, 2'd2, 4'd4, "R3 4bpp scale4");
        play(8'h7E, 2'd3, 4'd1, "R3 4bpp code3");
        // index 8 and 0 give the same colour (R4)
        play(8'h80, 2'd2, 4'd1, "R4 index bit3 ignored");
        play(8'h2A, 2'd2, 4'd3, "R4 rgb bit order");
    endtask

    task automatic t_scale_zero;
        play(8'h96, 2'd1, 4'd0, "R6 scale0 as 1");
    endtask

    task automatic t_no_ready;
        @(negedge clk);
        stage0 = 1'b1; pix_ready = 1'b0;
        #1 chk("R5 no ack without ready", int'(load_ack), 0);
        @(negedge clk);
        stage0 = 1'b0; pix_ready = 1'b1;
        #1 chk("R5 no ack without stage0", int'(load_ack), 0);
        @(negedge clk);
        pix_ready = 1'b0;
        #1 chk("R5 still idle black", int'(rgb), 0);
    endtask

    task automatic t_blank;
        logic [7:0] b;
        b = 8'hB4;
        do_load(b, 2'd0, 4'd2);
        // slot 0 for two clocks, slot 1 for one clock, then blank
        #1 chk("R7 pre-blank slot0", int'(rgb), exp_color(b, 2'd0, 0));
        @(negedge clk);
        #1 chk("R7 pre-blank slot0b", int'(rgb), exp_color(b, 2'd0, 0));
        @(negedge clk);
        #1 chk("R7 pre-blank slot1", int'(rgb), exp_color(b, 2'd0, 1));
        @(negedge clk);
        blank = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1 chk("R7 black while blank", int'(rgb), 0);
            @(negedge clk);
        end
        blank = 1'b0;
        #1 chk("R7 resume slot1 remaining", int'(rgb), exp_color(b, 2'd0, 1));
        @(negedge clk);
        for (int k = 2; k < 8; k++) begin
            for (int r = 0; r < 2; r++) begin
                #1 chk("R7 after resume", int'(rgb), exp_color(b, 2'd0, k));
                @(negedge clk);
            end
        end
        #1 chk("R7 idle after blanked byte", int'(rgb), 0);
    endtask

    task automatic t_collide;
        logic [7:0] a;
        logic [7:0] b;
        a = 8'h4D; b = 8'hA3;
        do_load(a, 2'd2, 4'd2);
        #1 chk("R8 first slot", int'(rgb), exp_color(a, 2'd2, 0));
        @(negedge clk);
        // request during shifting: ignored
        scr_byte = b; stage0 = 1'b1; pix_ready = 1'b1; bpp_sel = 2'd0; hscale = 4'd1;
        #1 chk("R8 no ack while busy", int'(load_ack), 0);
        chk("R8 output unaffected", int'(rgb), exp_color(a, 2'd2, 0));
        @(negedge clk);
        #1 chk("R8 busy slot1", int'(rgb), exp_color(a, 2'd2, 1));
        chk("R8 no ack busy slot1", int'(load_ack), 0);
        @(negedge clk);
        #1 chk("R8 final slot held", int'(rgb), exp_color(a, 2'd2, 1));
        chk("R8 no ack final slot", int'(load_ack), 0);
        @(negedge clk);
        #1 chk("R8 ack in first idle cycle", int'(load_ack), 1);
        chk("R8 idle black", int'(rgb), 0);
        @(negedge clk);
        stage0 = 1'b0; pix_ready = 1'b0;
        for (int k = 0; k < 8; k++) begin
            #1 chk("R8 next byte", int'(rgb), exp_color(b, 2'd0, k));
            @(negedge clk);
        end
        #1 chk("R8 idle at end", int'(rgb), 0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        t_reset();
        t_one_bpp();
        t_two_bpp();
        t_four_bpp();
        t_scale_zero();
        t_no_ready();
        t_blank();
        t_collide();
        done = 1'b1;
        summary();
    end

endmodule